// File: doc/BRIEF.md
# CSR Read-Modify-Write Access Unit

This block holds a small set of control and status registers and carries out the six read-modify-write operations on them. Three operations take a full-width register operand and three take a 5-bit immediate. Each operation either replaces the register, sets bits in it, or clears bits in it. Each request carries an operation code, a 12-bit register address, the operand, a flag that says the operand field is zero (source x0, or a zero immediate), the privilege level of the requester, and the address of the instruction. The block returns the value the register held before the operation and commits the new value when the operation writes.

Some accesses are forbidden. These are a write attempt to a read-only register, an access below the register's required privilege, an unimplemented address, and an undefined operation code. A forbidden access changes no register except the trap registers: it loads the cause register with the illegal-instruction code and the exception-PC register with the instruction address. The response is then flagged illegal, so the consumer can drop the destination write. The registers are a scratch register, a status register with a read-only width field, a free-running cycle counter, a cause register and an exception-PC register.

Requests enter through a valid/ready port and responses leave through a valid/ready port. There is one response slot. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. Its response appears on the next cycle and is held unchanged until `resp_ready` is high. `req_ready` is low only while a response is waiting and `resp_ready` is low, so back-pressure from the consumer reaches the requester within the same cycle.

Top module: `csr_rmw_unit`

## Requirements
- R1: `req_ready` equals `!resp_valid || resp_ready`. The response of an accepted request is valid in the following cycle and stays valid, with `resp_rdata` and `resp_illegal` unchanged, while `resp_ready` is low.
- R2: The write operations (op 3'b001 register, 3'b101 immediate) return the old value and replace the register with the operand.
- R3: The set operations (op 3'b010, 3'b110) return the old value and store the old value OR the operand.
- R4: The clear operations (op 3'b011, 3'b111) return the old value and store the old value AND the inverted operand.
- R5: The immediate forms (op bit 2 set) use `req_src[4:0]`, zero-extended, as the operand and ignore the upper bits.
- R6: A set or clear with `req_src_zero` high performs no write, so it is legal on a read-only register.
- R7: An address with bits [11:10] = 2'b11 is read-only. Any write attempt to it is illegal, including a write operation with `req_src_zero` high. The cycle counter sits at 12'hC00.
- R8: The access is illegal when `req_priv` (0 user, 1 supervisor, 3 machine) is below address bits [9:8]. Status is at 12'h100, so a user access to status is illegal.
- R9: An illegal access returns `resp_rdata` = 0 with `resp_illegal` high and changes no register. It loads cause (12'h142) with 2 and exception-PC (12'h141) with `req_pc`.
- R10: With XLEN 64, status bits [33:32] read 2'b10 when user mode exists and 2'b00 when it does not, and writes to them are ignored. Only the bits set in `STATUS_WMASK` are stored.
- R11: The cycle counter (12'hC00) advances by one every clock. Two reads differ by the number of cycles between their acceptance edges.
- R12: An unimplemented address (anything other than 12'h100, 12'h140 scratch, 12'h141, 12'h142, 12'hC00) is illegal. Op codes 3'b000 and 3'b100 are illegal.
- R13: After reset `resp_valid` is low, and scratch, cause, exception-PC and the writable status bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Operation code: bit 2 immediate form, bits [1:0] write/set/clear |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Register operand, or immediate in bits [4:0] |
| req_src_zero | input | 1 | Operand field is x0 or a zero immediate |
| req_priv | input | 2 | Privilege level of the requester |
| req_pc | input | XLEN | Address of the requesting instruction |
| resp_valid | output | 1 | Response present |
| resp_ready | input | 1 | Consumer takes the response |
| resp_rdata | output | XLEN | Previous register value, zero when illegal |
| resp_illegal | output | 1 | Access was illegal, destination write must be dropped |

## Verification
The bench builds two copies at XLEN 64, one with user mode present and one without it. Both get the same requests. This brings both encodings of the status width field within reach from a single run. The 64-bit width lets 5-bit immediates be driven with the upper operand bits all set, which shows that they are dropped. A mask that leaves out bits 33:32 lets an all-ones status write show that the field does not move. The cycle counter is checked by relative reads timed against the bench's own cycle count.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'b00,
    KIND_WRITE = 2'b01,
    KIND_SET   = 2'b10,
    KIND_CLEAR = 2'b11
  } rmw_kind_e;

  localparam logic [11:0] ADDR_STATUS  = 12'h100;
  localparam logic [11:0] ADDR_SCRATCH = 12'h140;
  localparam logic [11:0] ADDR_EPC     = 12'h141;
  localparam logic [11:0] ADDR_CAUSE   = 12'h142;
  localparam logic [11:0] ADDR_CYCLE   = 12'hC00;

  localparam int unsigned IMM_W         = 5;
  localparam int unsigned CAUSE_ILLEGAL = 2;

  typedef struct packed {
    rmw_kind_e kind;
    logic      immediate;
    logic      write_intent;
    logic      illegal;
  } access_verdict_t;

  function automatic rmw_kind_e op_kind(input logic [2:0] op);
    return rmw_kind_e'(op[1:0]);
  endfunction

endpackage

// File: rtl/csr_access_check.sv
module csr_access_check
  import csr_rmw_pkg::*;
(
  input  logic [2:0]      op,
  input  logic [11:0]     addr,
  input  logic            src_zero,
  input  logic [1:0]      priv,
  output access_verdict_t verdict
);

  rmw_kind_e kind;
  logic      implemented;
  logic      write_intent;
  logic      priv_fault;
  logic      ro_fault;

  always_comb begin
    kind        = op_kind(op);
    implemented = (addr == ADDR_STATUS)  || (addr == ADDR_SCRATCH) ||
                  (addr == ADDR_EPC)     || (addr == ADDR_CAUSE)   ||
                  (addr == ADDR_CYCLE);
    // set/clear with a zero operand field is a pure read
    write_intent = (kind == KIND_WRITE) ||
                   (((kind == KIND_SET) || (kind == KIND_CLEAR)) && !src_zero);
    priv_fault  = (priv < addr[9:8]);
    ro_fault    = write_intent && (addr[11:10] == 2'b11);

    verdict.kind         = kind;
    verdict.immediate    = op[2];
    verdict.write_intent = write_intent;
    verdict.illegal      = !implemented || (kind == KIND_NONE) ||
                           priv_fault || ro_fault;
  end

endmodule

// File: rtl/csr_rmw_alu.sv
module csr_rmw_alu
  import csr_rmw_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  rmw_kind_e        kind,
  input  logic             immediate,
  input  logic [XLEN-1:0]  src,
  input  logic [XLEN-1:0]  old_val,
  output logic [XLEN-1:0]  new_val
);

  logic [XLEN-1:0] operand;

  always_comb begin
    operand = immediate ? XLEN'(src[IMM_W-1:0]) : src;
    unique case (kind)
      KIND_WRITE: new_val = operand;
      KIND_SET:   new_val = old_val | operand;
      KIND_CLEAR: new_val = old_val & ~operand;
      default:    new_val = old_val;
    endcase
  end

endmodule

// File: rtl/csr_regfile.sv
module csr_regfile
  import csr_rmw_pkg::*;
#(
  parameter int unsigned     XLEN         = 64,
  parameter bit              HAS_USER     = 1'b1,
  parameter logic [XLEN-1:0] STATUS_WMASK = XLEN'(64'h0000_0000_000C_0122)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [11:0]      addr,
  input  logic             wr_en,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             trap_en,
  input  logic [XLEN-1:0]  trap_pc,
  output logic [XLEN-1:0]  rd_data
);

  localparam logic [XLEN-1:0] CAUSE_CODE = XLEN'(CAUSE_ILLEGAL);

  logic [XLEN-1:0] scratch_q;
  logic [XLEN-1:0] status_q;
  logic [XLEN-1:0] epc_q;
  logic [XLEN-1:0] cause_q;
  logic [XLEN-1:0] cycle_q;
  logic [XLEN-1:0] uxl_ro;

  generate
    if (XLEN == 64 && HAS_USER) begin : g_uxl_64
      always_comb begin
        uxl_ro        = '0;
        uxl_ro[33:32] = 2'b10;
      end
    end else begin : g_uxl_none
      assign uxl_ro = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) cycle_q <= '0;
    else        cycle_q <= cycle_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scratch_q <= '0;
      status_q  <= '0;
      epc_q     <= '0;
      cause_q   <= '0;
    end else if (trap_en) begin
      cause_q <= CAUSE_CODE;
      epc_q   <= trap_pc;
    end else if (wr_en) begin
      unique case (addr)
        ADDR_SCRATCH: scratch_q <= wr_data;
        ADDR_STATUS:  status_q  <= wr_data & STATUS_WMASK;
        ADDR_EPC:     epc_q     <= wr_data;
        ADDR_CAUSE:   cause_q   <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_SCRATCH: rd_data = scratch_q;
      ADDR_STATUS:  rd_data = status_q | uxl_ro;
      ADDR_EPC:     rd_data = epc_q;
      ADDR_CAUSE:   rd_data = cause_q;
      ADDR_CYCLE:   rd_data = cycle_q;
      default:      rd_data = '0;
    endcase
  end

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
  import csr_rmw_pkg::*;
#(
  parameter int unsigned     XLEN         = 64,
  parameter bit              HAS_USER     = 1'b1,
  parameter logic [XLEN-1:0] STATUS_WMASK = XLEN'(64'h0000_0000_000C_0122)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [11:0]      req_addr,
  input  logic [XLEN-1:0]  req_src,
  input  logic             req_src_zero,
  input  logic [1:0]       req_priv,
  input  logic [XLEN-1:0]  req_pc,
  output logic             resp_valid,
  input  logic             resp_ready,
  output logic [XLEN-1:0]  resp_rdata,
  output logic             resp_illegal
);

  access_verdict_t verdict;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] new_val;
  logic            accept;
  logic            commit;
  logic            trap;

  assign req_ready = !resp_valid || resp_ready;
  assign accept    = req_valid && req_ready;
  assign commit    = accept && verdict.write_intent && !verdict.illegal;
  assign trap      = accept && verdict.illegal;

  csr_access_check u_check (
    .op       (req_op),
    .addr     (req_addr),
    .src_zero (req_src_zero),
    .priv     (req_priv),
    .verdict  (verdict)
  );

  csr_rmw_alu #(.XLEN(XLEN)) u_alu (
    .kind      (verdict.kind),
    .immediate (verdict.immediate),
    .src       (req_src),
    .old_val   (old_val),
    .new_val   (new_val)
  );

  csr_regfile #(
    .XLEN         (XLEN),
    .HAS_USER     (HAS_USER),
    .STATUS_WMASK (STATUS_WMASK)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (req_addr),
    .wr_en   (commit),
    .wr_data (new_val),
    .trap_en (trap),
    .trap_pc (req_pc),
    .rd_data (old_val)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_rdata   <= '0;
      resp_illegal <= 1'b0;
    end else if (accept) begin
      resp_valid   <= 1'b1;
      resp_rdata   <= verdict.illegal ? '0 : old_val;
      resp_illegal <= verdict.illegal;
    end else if (resp_ready) begin
      resp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/csr_rmw_unit_checker.sv
module csr_rmw_unit_checker
  import csr_rmw_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter bit          HAS_USER = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [2:0]       req_op,
  input logic [11:0]      req_addr,
  input logic             req_src_zero,
  input logic [1:0]       req_priv,
  input logic             resp_valid,
  input logic             resp_ready,
  input logic [XLEN-1:0]  resp_rdata,
  input logic             resp_illegal
);

  logic accept;
  logic wants_write;
  logic known_addr;

  assign accept      = req_valid && req_ready;
  assign wants_write = (req_op[1:0] == 2'b01) ||
                       ((req_op[1:0] != 2'b00) && !req_src_zero);
  assign known_addr  = (req_addr == ADDR_STATUS) || (req_addr == ADDR_SCRATCH) ||
                       (req_addr == ADDR_EPC) || (req_addr == ADDR_CAUSE) ||
                       (req_addr == ADDR_CYCLE);

  assert_resp_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=>
      (resp_valid && $stable(resp_rdata) && $stable(resp_illegal)));

  assert_stall_blocks_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |-> !req_ready);

  assert_readonly_write_traps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wants_write && (req_addr[11:10] == 2'b11)) |=> (resp_valid && resp_illegal));

  assert_user_status_traps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (req_priv == 2'b00) && (req_addr == ADDR_STATUS)) |=> resp_illegal);

  assert_trap_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && resp_illegal) |-> (resp_rdata == '0));

  assert_unknown_addr_traps_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !known_addr) |=> resp_illegal);

  generate
    if (XLEN == 64) begin : g_uxl_chk
      assert_uxl_field_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && (req_addr == ADDR_STATUS) && (req_priv != 2'b00) &&
         (req_op[1:0] != 2'b00))
        |=> (resp_rdata[33:32] == (HAS_USER ? 2'b10 : 2'b00)));
    end
  endgenerate

endmodule

bind csr_rmw_unit csr_rmw_unit_checker #(
  .XLEN     (XLEN),
  .HAS_USER (HAS_USER)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_op       (req_op),
  .req_addr     (req_addr),
  .req_src_zero (req_src_zero),
  .req_priv     (req_priv),
  .resp_valid   (resp_valid),
  .resp_ready   (resp_ready),
  .resp_rdata   (resp_rdata),
  .resp_illegal (resp_illegal)
);

// File: tb/csr_rmw_unit_test.sv
`timescale 1ns/1ps
module csr_rmw_unit_test;
  localparam int unsigned XLEN = 64;
  localparam logic [63:0] WMASK = 64'h0000_0000_000C_0122;
  localparam logic [63:0] UXL2  = 64'h0000_0002_0000_0000;
  localparam logic [11:0] A_STATUS = 12'h100, A_SCRATCH = 12'h140,
                          A_EPC = 12'h141, A_CAUSE = 12'h142,
                          A_CYCLE = 12'hC00, A_BOGUS = 12'h5A5;
  localparam logic [2:0] OP_RW = 3'b001, OP_RS = 3'b010, OP_RC = 3'b011,
                         OP_RWI = 3'b101, OP_RSI = 3'b110, OP_RCI = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             req_valid = 1'b0;
  logic             req_ready, req_ready2;
  logic [2:0]       req_op = '0;
  logic [11:0]      req_addr = '0;
  logic [XLEN-1:0]  req_src = '0;
  logic             req_src_zero = 1'b0;
  logic [1:0]       req_priv = 2'b11;
  logic [XLEN-1:0]  req_pc = '0;
  logic             resp_valid, resp_valid2;
  logic             resp_ready = 1'b1;
  logic [XLEN-1:0]  resp_rdata, resp_rdata2;
  logic             resp_illegal, resp_illegal2;

  csr_rmw_unit #(.XLEN(XLEN), .HAS_USER(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_src(req_src),
    .req_src_zero(req_src_zero), .req_priv(req_priv), .req_pc(req_pc),
    .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_rdata(resp_rdata), .resp_illegal(resp_illegal));

  csr_rmw_unit #(.XLEN(XLEN), .HAS_USER(1'b0)) uut_nouser (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready2),
    .req_op(req_op), .req_addr(req_addr), .req_src(req_src),
    .req_src_zero(req_src_zero), .req_priv(req_priv), .req_pc(req_pc),
    .resp_valid(resp_valid2), .resp_ready(resp_ready),
    .resp_rdata(resp_rdata2), .resp_illegal(resp_illegal2));

  int checks = 0;
  int fails  = 0;
  int unsigned cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [63:0] m_scratch = '0, m_status = '0, m_epc = '0, m_cause = '0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_illegal(input logic [2:0] op, input logic [11:0] a,
                                     input bit z, input logic [1:0] p);
    bit known = (a == A_STATUS) || (a == A_SCRATCH) || (a == A_EPC) ||
                (a == A_CAUSE) || (a == A_CYCLE);
    bit wi = (op[1:0] == 2'b01) || ((op[1:0] != 2'b00) && !z);
    return !known || (op[1:0] == 2'b00) || (p < a[9:8]) ||
           (wi && (a[11:10] == 2'b11));
  endfunction

  function automatic logic [63:0] model_read(input logic [11:0] a);
    case (a)
      A_SCRATCH: return m_scratch;
      A_STATUS:  return (m_status & WMASK) | UXL2;
      A_EPC:     return m_epc;
      A_CAUSE:   return m_cause;
      default:   return '0;
    endcase
  endfunction

  // one request with a free response path; checks against the model
  task automatic txn(input string tag, input logic [2:0] op, input logic [11:0] a,
                     input logic [63:0] src, input bit z, input logic [1:0] p,
                     input logic [63:0] pc, output logic [63:0] rd,
                     output int unsigned acc);
    logic [63:0] old, opnd, nv;
    bit ill, wi;
    @(negedge clk);
    req_op = op; req_addr = a; req_src = src; req_src_zero = z;
    req_priv = p; req_pc = pc; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    acc = cyc;
    ill  = exp_illegal(op, a, z, p);
    old  = model_read(a);
    @(negedge clk);
    req_valid = 1'b0;
    rd = resp_rdata;
    check({tag, " illegal flag"}, {63'd0, resp_illegal}, {63'd0, ill});
    check({tag, " resp_valid"}, {63'd0, resp_valid}, 64'd1);
    if (ill) begin
      check({tag, " trap data zero R9"}, resp_rdata, 64'd0);
      m_cause = 64'd2; m_epc = pc;
    end else begin
      if (a != A_CYCLE) check({tag, " old value"}, resp_rdata, old);
      if (a == A_STATUS)
        check({tag, " no-user status R10"}, resp_rdata2, m_status & WMASK);
      wi   = (op[1:0] == 2'b01) || !z;
      opnd = op[2] ? {59'd0, src[4:0]} : src;
      case (op[1:0])
        2'b01:   nv = opnd;
        2'b10:   nv = old | opnd;
        default: nv = old & ~opnd;
      endcase
      if (wi) begin
        case (a)
          A_SCRATCH: m_scratch = nv;
          A_STATUS:  m_status  = nv & WMASK;
          A_EPC:     m_epc     = nv;
          A_CAUSE:   m_cause   = nv;
          default: ;
        endcase
      end
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [63:0] rd, rd_b, hold;
    int unsigned acc, acc_b;
    int unsigned seed;
    seed = $urandom(32'hC5A1);

    repeat (4) @(negedge clk);
    check("R13 resp_valid in reset", {63'd0, resp_valid}, 64'd0);
    check("R1 req_ready idle", {63'd0, req_ready}, 64'd1);
    rst_n = 1'b1;

    txn("R13 scratch reset", OP_RS, A_SCRATCH, 0, 1, 3, 0, rd, acc);
    check("R13 scratch zero", rd, 64'd0);
    txn("R13 status reset", OP_RSI, A_STATUS, 0, 1, 3, 0, rd, acc);
    check("R10 uxl reads 2", rd, UXL2);
    check("R10 uxl absent reads 0", resp_rdata2, 64'd0);

    txn("R5 imm write", OP_RWI, A_SCRATCH, 64'hFFFF_FFFF_FFFF_FFE9, 0, 3, 0, rd, acc);
    txn("R5 readback", OP_RS, A_SCRATCH, 0, 1, 3, 0, rd, acc);
    check("R5 zero-extended imm", rd, 64'h9);
    txn("R3 set imm", OP_RSI, A_SCRATCH, 64'h6, 0, 3, 0, rd, acc);
    check("R3 set returns old", rd, 64'h9);
    txn("R4 clear imm", OP_RCI, A_SCRATCH, 64'h3, 0, 3, 0, rd, acc);
    check("R4 clear returns old", rd, 64'hF);
    txn("R2 write reg", OP_RW, A_SCRATCH, 64'h1234_5678_9ABC_DEF0, 0, 1, 0, rd, acc);
    check("R2 write returns old", rd, 64'hC);
    txn("R4 clear reg", OP_RC, A_SCRATCH, 64'h0000_0000_0000_FF00, 0, 1, 0, rd, acc);
    txn("R3 set reg", OP_RS, A_SCRATCH, 64'h0F, 0, 1, 0, rd, acc);
    txn("R2 readback", OP_RS, A_SCRATCH, 0, 1, 1, 0, rd, acc);
    check("R4 R3 combined result", rd, 64'h1234_5678_9ABC_00FF);

    txn("R6 user read cycle", OP_RS, A_CYCLE, 0, 1, 0, 0, rd, acc);
    txn("R6 imm read cycle", OP_RCI, A_CYCLE, 0, 1, 0, 0, rd_b, acc_b);
    check("R11 cycle delta", rd_b - rd, 64'(acc_b - acc));

    txn("R7 write x0 to cycle", OP_RW, A_CYCLE, 0, 1, 3, 64'h8000_0010, rd, acc);
    txn("R9 cause read", OP_RS, A_CAUSE, 0, 1, 3, 0, rd, acc);
    check("R9 cause code", rd, 64'd2);
    txn("R9 epc read", OP_RS, A_EPC, 0, 1, 3, 0, rd, acc);
    check("R9 epc captured", rd, 64'h8000_0010);
    txn("R7 clear cycle nonzero", OP_RCI, A_CYCLE, 64'h1, 0, 3, 64'h44, rd, acc);

    txn("R8 user reads status", OP_RS, A_STATUS, 0, 1, 0, 64'h8000_0100, rd, acc);
    txn("R9 user writes scratch", OP_RW, A_SCRATCH, 64'hDEAD, 0, 0, 64'h8000_0104, rd, acc);
    txn("R9 scratch kept", OP_RS, A_SCRATCH, 0, 1, 3, 0, rd, acc);
    check("R9 scratch unchanged", rd, 64'h1234_5678_9ABC_00FF);
    txn("R9 epc after user trap", OP_RS, A_EPC, 0, 1, 3, 0, rd, acc);
    check("R9 epc second trap", rd, 64'h8000_0104);

    txn("R10 status all ones", OP_RW, A_STATUS, '1, 0, 1, 0, rd, acc);
    txn("R10 status readback", OP_RS, A_STATUS, 0, 1, 1, 0, rd, acc);
    check("R10 masked with uxl", rd, WMASK | UXL2);
    check("R10 masked without uxl", resp_rdata2, WMASK);

    txn("R12 unknown addr", OP_RS, A_BOGUS, 0, 1, 3, 64'h60, rd, acc);
    txn("R12 op 000", 3'b000, A_SCRATCH, 0, 1, 3, 64'h64, rd, acc);
    txn("R12 op 100", 3'b100, A_SCRATCH, 5, 0, 3, 64'h68, rd, acc);

    // back-pressure
    @(negedge clk);
    resp_ready = 1'b0;
    req_op = OP_RS; req_addr = A_SCRATCH; req_src = '0; req_src_zero = 1'b1;
    req_priv = 2'b11; req_valid = 1'b1;
    @(negedge clk);
    hold = resp_rdata;
    check("R1 first response", hold, m_scratch);
    req_op = OP_RWI; req_src = 64'h5; req_src_zero = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 req_ready low in stall", {63'd0, req_ready}, 64'd0);
      check("R1 response held", resp_rdata, hold);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R1 queued request served", {63'd0, resp_valid}, 64'd1);
    check("R1 queued old value", resp_rdata, hold);
    m_scratch = 64'h5;
    txn("R1 queued write landed", OP_RS, A_SCRATCH, 0, 1, 3, 0, rd, acc);
    check("R1 scratch after stall", rd, 64'h5);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      logic [11:0] a;
      logic [63:0] src;
      logic [1:0] p;
      bit z;
      int unsigned k;
      op = 3'($urandom_range(0, 7));
      k = $urandom_range(0, 6);
      case (k)
        0: a = A_SCRATCH; 1: a = A_STATUS; 2: a = A_EPC; 3: a = A_CAUSE;
        4: a = A_CYCLE; 5: a = A_BOGUS; default: a = A_SCRATCH;
      endcase
      k = $urandom_range(0, 2);
      p = (k == 0) ? 2'b00 : (k == 1) ? 2'b01 : 2'b11;
      src = {$urandom, $urandom};
      if (op[2]) z = (src[4:0] == 5'd0);
      else begin
        z = ($urandom_range(0, 3) == 0);
        if (z) src = '0;
      end
      case (op[1:0])
        2'b01:   txn("R2 random", op, a, src, z, p, {$urandom, $urandom}, rd, acc);
        2'b10:   txn("R3 random", op, a, src, z, p, {$urandom, $urandom}, rd, acc);
        2'b11:   txn("R4 random", op, a, src, z, p, {$urandom, $urandom}, rd, acc);
        default: txn("R12 random", op, a, src, z, p, {$urandom, $urandom}, rd, acc);
      endcase
    end

    finish_run();
  end

endmodule